// File: doc/BRIEF.md
# Single-Pin Port with Boot Strap Sampling

This block controls one bidirectional pin that has three roles. While reset is asserted, the pin is held as an input. On the clock edge where reset is released, its level is captured as a strap. The strap decides where the boot control word comes from. A low level selects internal ROM at address FFF9H. A high level selects external memory. After that edge the pin is a general-purpose port. It stays an input until software writes the port data address for the first time. From then on it drives push-pull until the next reset. A read of the port always returns the level actually present on the pin.

When the mode input `rw_mode` is set (bit 3 of the system control word), the pin carries the processor read/write strobe instead of port data. It drives that strobe while the internal CPU is active and is an input otherwise. The port state is kept underneath and reappears unchanged when `rw_mode` is cleared.

A small state machine holds the port role. PS_STRAP is the state during reset and up to the release edge. PS_LISTEN is input-only port mode. PS_DRIVE is output port mode. The transitions are:
- PS_STRAP to PS_LISTEN on the release edge when no write is present.
- PS_STRAP to PS_DRIVE on the release edge when a write is present.
- PS_LISTEN to PS_DRIVE on a write.
- PS_DRIVE stays in PS_DRIVE.
- Any state returns to PS_STRAP on reset.

Top module: `strap_pin_port`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge with `rst_n` high, `pin_oe` is 0 for every value of `rw_mode` and `cpu_active`.
- R2: `boot_ext` is 0 during reset. On the first rising edge with `rst_n` high it takes the level of `pin_in` (1 = external memory, 0 = internal ROM at FFF9H).
- R3: After the strap edge, with `rw_mode` = 0 and no write made yet, `pin_oe` is 0.
- R4: A cycle with `wr_stb` = 1 makes `pin_oe` = 1 (with `rw_mode` = 0) from the next cycle on. Output mode is permanent until the next reset.
- R5: In port mode `pin_out` equals bit 0 of `wdata` from the most recent write, from the cycle after that write. The other bits of `wdata` have no effect.
- R6: `rdata` bit 0 always equals `pin_in` combinationally, and bits DATA_W-1..1 are 0, in every mode.
- R7: Outside PS_STRAP with `rw_mode` = 1, `pin_oe` equals `cpu_active` and `pin_out` equals `rw_level`, combinationally.
- R8: Writes made while `rw_mode` = 1 still update the port state. When `rw_mode` returns to 0, `pin_oe` and `pin_out` follow that port state.
- R9: After the strap edge, `boot_ext` does not change on writes, `rw_mode`, `cpu_active` or later levels of `pin_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe for the port data address |
| wdata | input | DATA_W | Write data; only bit 0 is used |
| rdata | output | DATA_W | Read data: pin level in bit 0, zeros above |
| rw_mode | input | 1 | Control-word bit 3: pin carries the read/write strobe |
| cpu_active | input | 1 | Internal CPU is active |
| rw_level | input | 1 | Read/write strobe level from the CPU |
| pin_in | input | 1 | Sensed pin level |
| pin_oe | output | 1 | Pin drive enable |
| pin_out | output | 1 | Pin drive value |
| boot_ext | output | 1 | Latched strap: 1 = external control word |

## Verification
The hardest case to reach is the release edge itself. The strap must be sampled at exactly that edge, and the drive must stay off before it even when `rw_mode` and `cpu_active` are both high. The bench resets the block once for each strap level. During reset it sweeps `rw_mode` and `cpu_active`, and it holds them high across the release. Right after the edge it flips `pin_in`, to show that the flag was frozen at the edge and not a cycle later. A second hard case is a first write made while the read/write strobe owns the pin. It is reached by writing with `rw_mode` set and then clearing `rw_mode`.

// File: rtl/strap_pin_pkg.sv
package strap_pin_pkg;

    typedef enum logic [1:0] {
        PS_STRAP  = 2'd0,
        PS_LISTEN = 2'd1,
        PS_DRIVE  = 2'd2
    } pin_state_e;

endpackage

// File: rtl/strap_pin_latch.sv
module strap_pin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic pin_in,
    output logic boot_ext
);

    logic boot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
        end else if (capture) begin
            boot_q <= pin_in;
        end
    end

    assign boot_ext = boot_q;

    // R2: the flag takes the pin level sampled at the capture edge
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (boot_q == $past(pin_in)));

    // R9: once captured, the flag never moves
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(boot_q));

endmodule

// File: rtl/strap_pin_datareg.sv
module strap_pin_datareg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pin_in,
    output logic              data_bit,
    output logic [DATA_W-1:0] rdata
);

    localparam int HI_W = DATA_W - 1;

    logic data_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b0;
        end else if (wr_stb) begin
            data_q <= wdata[0];
        end
    end

    assign data_bit = data_q;
    assign rdata    = {{HI_W{1'b0}}, pin_in};

    // R5: a write lands bit 0 in the data latch one cycle later
    p_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (data_q == $past(wdata[0])));

endmodule

// File: rtl/strap_pin_fsm.sv
module strap_pin_fsm
    import strap_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rw_mode,
    input  logic       cpu_active,
    input  logic       rw_level,
    input  logic       data_bit,
    output pin_state_e state_o,
    output logic       pin_oe,
    output logic       pin_out
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_STRAP:  state_d = wr_stb ? PS_DRIVE : PS_LISTEN;
            PS_LISTEN: state_d = wr_stb ? PS_DRIVE : PS_LISTEN;
            PS_DRIVE:  state_d = PS_DRIVE;
            default:   state_d = PS_STRAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_STRAP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pin_oe  = 1'b0;
        pin_out = 1'b0;
        unique case (state_q)
            PS_STRAP: begin
                pin_oe  = 1'b0;
                pin_out = 1'b0;
            end
            PS_LISTEN: begin
                pin_oe  = rw_mode ? cpu_active : 1'b0;
                pin_out = rw_mode ? rw_level : data_bit;
            end
            PS_DRIVE: begin
                pin_oe  = rw_mode ? cpu_active : 1'b1;
                pin_out = rw_mode ? rw_level : data_bit;
            end
            default: begin
                pin_oe  = 1'b0;
                pin_out = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R4: output mode is sticky until reset
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRIVE) |=> (state_q == PS_DRIVE));

    // R4: any write lands the port in output mode
    p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (state_q == PS_DRIVE));

    // R1: the strap state lasts exactly one release edge
    p_strap_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q != PS_STRAP));

endmodule

// File: rtl/strap_pin_port.sv
module strap_pin_port
    import strap_pin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rw_mode,
    input  logic              cpu_active,
    input  logic              rw_level,
    input  logic              pin_in,
    output logic              pin_oe,
    output logic              pin_out,
    output logic              boot_ext
);

    pin_state_e state;
    logic       data_bit;

    strap_pin_datareg #(.DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wdata    (wdata),
        .pin_in   (pin_in),
        .data_bit (data_bit),
        .rdata    (rdata)
    );

    strap_pin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .rw_mode    (rw_mode),
        .cpu_active (cpu_active),
        .rw_level   (rw_level),
        .data_bit   (data_bit),
        .state_o    (state),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out)
    );

    strap_pin_latch u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (state == PS_STRAP),
        .pin_in   (pin_in),
        .boot_ext (boot_ext)
    );

    // R1: no drive while the strap is being sampled
    p_quiet_strap_r1: assert property (@(posedge clk)
        (state == PS_STRAP) |-> !pin_oe);

    // R7: in strobe mode the enable follows the CPU flag once past the strap
    p_rw_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_mode && state != PS_STRAP) |-> (pin_oe == cpu_active));

endmodule

// File: tb/strap_pin_port_test.sv
module strap_pin_port_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rw_mode = 1'b0;
    logic          cpu_active = 1'b0;
    logic          rw_level = 1'b0;
    logic          pin_in = 1'b0;
    logic          pin_oe;
    logic          pin_out;
    logic          boot_ext;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    strap_pin_port #(.DATA_W(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wdata      (wdata),
        .rdata      (rdata),
        .rw_mode    (rw_mode),
        .cpu_active (cpu_active),
        .rw_level   (rw_level),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .boot_ext   (boot_ext)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one write cycle: strobe during a full clock, result visible at next negedge
    task automatic do_write(input logic [DW-1:0] v);
        wr_stb = 1'b1;
        wdata  = v;
        @(negedge clk);
        wr_stb = 1'b0;
        wdata  = ~v;
        #1;
    endtask

    initial begin
        for (int sv = 0; sv < 2; sv++) begin
            logic [DW-1:0] last;
            rst_n = 1'b0;
            pin_in = sv[0];
            rw_mode = 1'b0;
            cpu_active = 1'b0;
            @(negedge clk);
            // R1 sweep of strobe mode and CPU flag during reset
            for (int m = 0; m < 4; m++) begin
                rw_mode = m[1];
                cpu_active = m[0];
                rw_level = m[0];
                @(negedge clk);
                #1;
                check("R1 oe in reset", int'(pin_oe), 0);
                check("R2 flag in reset", int'(boot_ext), 0);
            end
            // release reset with strobe mode and CPU active held high
            rw_mode = 1'b1;
            cpu_active = 1'b1;
            rst_n = 1'b1;
            #1;
            check("R1 oe before release edge", int'(pin_oe), 0);
            @(negedge clk);
            pin_in = ~sv[0];
            #1;
            check("R2 strap captured", int'(boot_ext), sv);
            check("R7 oe follows cpu", int'(pin_oe), 1);
            rw_mode = 1'b0;
            #1;
            check("R3 input after strap", int'(pin_oe), 0);
            @(negedge clk);
            check("R9 flag ignores pin", int'(boot_ext), sv);
            // R6 read-back of pin level in listen mode
            for (int p = 0; p < 2; p++) begin
                pin_in = p[0];
                #1;
                check("R6 rdata listen", int'(rdata), p);
            end
            if (sv == 0) begin
                // first write in port mode
                do_write(8'hFE);
                check("R4 drive after write", int'(pin_oe), 1);
                check("R5 value after write", int'(pin_out), 0);
            end else begin
                // R8: first write made while the strobe owns the pin
                rw_mode = 1'b1;
                cpu_active = 1'b0;
                do_write(8'h01);
                check("R8 strobe still owns oe", int'(pin_oe), 0);
                rw_mode = 1'b0;
                #1;
                check("R8 port oe resumes", int'(pin_oe), 1);
                check("R8 port value resumes", int'(pin_out), 1);
            end
            // R5 write sweep over data patterns
            last = '0;
            for (int w = 0; w < 256; w += 37) begin
                last = w[DW-1:0] ^ DW'(sv * 8'h5A);
                do_write(last);
                check("R4 stays driving", int'(pin_oe), 1);
                check("R5 bit0 only", int'(pin_out), int'(last[0]));
                check("R9 flag ignores writes", int'(boot_ext), sv);
            end
            // R7 strobe mode combinations
            rw_mode = 1'b1;
            for (int c = 0; c < 4; c++) begin
                cpu_active = c[1];
                rw_level = c[0];
                pin_in = c[0];
                #1;
                check("R7 oe", int'(pin_oe), c >> 1);
                check("R7 value", int'(pin_out), c & 1);
                check("R6 rdata rw mode", int'(rdata), c & 1);
            end
            rw_mode = 1'b0;
            #1;
            check("R8 value after strobe", int'(pin_out), int'(last[0]));
            check("R4 oe after strobe", int'(pin_oe), 1);
            @(negedge clk);
            check("R9 flag final", int'(boot_ext), sv);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule